// File: doc/BRIEF.md
# Receive Output Polarity and Retiming Selector

This block is the last stage of a line receiver. It takes a data rail and a violation-flag rail that clock recovery has already aligned to the recovered clock, and turns them into the two receive output rails. Two independent controls shape the result. One sets the active level of both rails. The other picks which edge of the recovered clock launches them. Together they give four retiming modes. Every mode registers the rails once on the rising edge. A falling-edge launch adds a second register on the negative edge, which is fed from the first.

A third control group is a vector of loopback enables. When every enable in the vector is set, the block bypasses recovery. The raw return-to-zero slicer pulses then pass straight to the outputs with no register in the path. In this bypass the edge choice has no effect, but the polarity control still applies, because inversion sits after the output selector. Any other loopback pattern leaves the retimed path in use.

Top module: `rx_retime_sel`

## Requirements
- R1: While `rst_n` is low, with the retimed path selected, both output rails sit at their inactive level: 0 when `pol_hi` is 1, and 1 when `pol_hi` is 0.
- R2: With `rise_sel` = 1, the values of `rt_data` and `rt_flag` sampled at a rising edge of `clk_rec` appear on `rx_d` and `rx_v` just after that same edge. They hold until the next rising edge.
- R3: With `rise_sel` = 0, the values sampled at a rising edge appear on the outputs just after the following falling edge. Until that falling edge, the outputs keep the values sampled one rising edge earlier.
- R4: With `pol_hi` = 0, each output rail is the bitwise complement of its active-high value. With `pol_hi` = 1, it equals that value.
- R5: When all `LB_N` bits of `lb_ctl` are 1 (bypass), `rx_d` follows `sl_pos` and `rx_v` follows `sl_neg` combinationally, within the same cycle and without waiting for a clock edge.
- R6: In bypass, `rise_sel` has no effect on the outputs.
- R7: Any `lb_ctl` pattern other than all ones keeps the retimed outputs selected. This includes all zeros and the pattern with exactly one bit cleared.
- R8: In bypass, `pol_hi` = 0 inverts the slicer rails on the outputs, just as it inverts the retimed rails.
- R9: The flag rail `rx_v` has the same latency and launch edge as the data rail `rx_d` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rec | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_hi | input | 1 | 1 selects active-high outputs, 0 selects active-low |
| rise_sel | input | 1 | 1 launches on the rising edge, 0 on the falling edge |
| lb_ctl | input | LB_N | Loopback enables; all ones selects bypass |
| rt_data | input | 1 | Retimed receive data, active-high |
| rt_flag | input | 1 | Retimed violation flag, active-high |
| sl_pos | input | 1 | Raw positive slicer pulse (RZ), active-high |
| sl_neg | input | 1 | Raw negative slicer pulse (RZ), active-high |
| rx_d | output | 1 | Receive data rail |
| rx_v | output | 1 | Receive flag rail (carries the negative slicer rail in bypass) |

## Verification
The bench checks the output twice per cycle: once just after the rising edge and once just after the falling edge. This separates the two launch edges. A design that wired the falling-edge register to the raw input, or that used only one edge, would show new data half a cycle early or late.

Loopback patterns with one bit cleared catch a bypass decoder built with OR instead of AND. Bypass vectors that toggle the edge select catch a design that still registers the slicer rails. Bypass vectors with active-low polarity catch inversion placed before the selector.

Reset is checked under both polarities. A design that reset the flops to the output level instead of the internal level would fail there.

// File: rtl/rx_retime_sel.sv
module rx_retime_sel #(
  parameter int LB_N = 12
) (
  input  logic            clk_rec,
  input  logic            rst_n,
  input  logic            pol_hi,
  input  logic            rise_sel,
  input  logic [LB_N-1:0] lb_ctl,
  input  logic            rt_data,
  input  logic            rt_flag,
  input  logic            sl_pos,
  input  logic            sl_neg,
  output logic            rx_d,
  output logic            rx_v
);

  logic       byp;
  logic [1:0] pos_q;
  logic [1:0] neg_q;
  logic [1:0] pick;

  assign byp = &lb_ctl;

  always_ff @(posedge clk_rec or negedge rst_n)
    if (!rst_n) pos_q <= 2'b00;
    else        pos_q <= {rt_flag, rt_data};

  always_ff @(negedge clk_rec or negedge rst_n)
    if (!rst_n) neg_q <= 2'b00;
    else        neg_q <= pos_q;

  assign pick = byp ? {sl_neg, sl_pos} : (rise_sel ? pos_q : neg_q);

  assign {rx_v, rx_d} = pol_hi ? pick : ~pick;

  // R2, R9
  p_rise_path_r2: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (!byp && rise_sel && pol_hi) |=>
      (byp || !rise_sel || !pol_hi ||
       (rx_d == $past(rt_data) && rx_v == $past(rt_flag))))
    else $error("p_rise_path_r2");

  // R3, R9
  p_fall_path_r3: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (!byp && !rise_sel && pol_hi) |=>
      (byp || rise_sel || !pol_hi ||
       (rx_d == $past(rt_data) && rx_v == $past(rt_flag))))
    else $error("p_fall_path_r3");

  p_invert_r4: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (!byp && !pol_hi) |=>
      (byp || pol_hi ||
       (rx_d != $past(rt_data) && rx_v != $past(rt_flag))))
    else $error("p_invert_r4");

  p_bypass_r5: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (byp && pol_hi) |-> (rx_d == sl_pos && rx_v == sl_neg))
    else $error("p_bypass_r5");

  p_bypass_inv_r8: assert property (@(posedge clk_rec) disable iff (!rst_n)
    (byp && !pol_hi) |-> (rx_d != sl_pos && rx_v != sl_neg))
    else $error("p_bypass_inv_r8");

endmodule

// File: tb/rx_retime_sel_bench.sv
module rx_retime_sel_bench;
  localparam int LB_N = 12;

  logic            clk_rec = 1'b0;
  logic            rst_n = 1'b0;
  logic            pol_hi = 1'b1;
  logic            rise_sel = 1'b1;
  logic [LB_N-1:0] lb_ctl = '0;
  logic            rt_data = 1'b0;
  logic            rt_flag = 1'b0;
  logic            sl_pos = 1'b0;
  logic            sl_neg = 1'b0;
  logic            rx_d;
  logic            rx_v;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_rec = ~clk_rec;

  rx_retime_sel #(.LB_N(LB_N)) u_rx_retime_sel (
    .clk_rec(clk_rec), .rst_n(rst_n), .pol_hi(pol_hi), .rise_sel(rise_sel),
    .lb_ctl(lb_ctl), .rt_data(rt_data), .rt_flag(rt_flag),
    .sl_pos(sl_pos), .sl_neg(sl_neg), .rx_d(rx_d), .rx_v(rx_v)
  );

  // fields: [6] pol_hi, [5] rise_sel, [4] bypass, [3] rt_data, [2] rt_flag, [1] sl_pos, [0] sl_neg
  localparam logic [6:0] VEC [16] = '{
    7'b1_1_0_10_00, 7'b1_1_0_01_11, 7'b1_1_0_11_00, 7'b1_0_0_00_11,
    7'b1_0_0_10_00, 7'b1_0_0_01_00, 7'b0_1_0_11_00, 7'b0_0_0_10_11,
    7'b0_1_0_01_10, 7'b1_1_1_10_10, 7'b1_0_1_01_01, 7'b0_1_1_00_11,
    7'b0_0_1_11_10, 7'b1_0_0_11_01, 7'b0_0_0_00_01, 7'b1_1_0_10_10
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rails {rx_v,rx_d} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] lvl(input logic ph, input logic [1:0] v);
    return ph ? v : ~v;
  endfunction

  function automatic logic [LB_N-1:0] nonbyp(input int i);
    case (i % 3)
      0: return '0;
      1: return {1'b0, {(LB_N-1){1'b1}}};
      default: return {{(LB_N-1){1'b1}}, 1'b0};
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] prev;
    logic [1:0] cur;
    // R1: reset level under both polarities
    #1;
    chk("R1 active-high reset", {rx_v, rx_d}, 2'b00);
    pol_hi = 1'b0;
    #1;
    chk("R1 active-low reset", {rx_v, rx_d}, 2'b11);
    pol_hi = 1'b1;
    repeat (2) @(posedge clk_rec);
    #1 rst_n = 1'b1;
    prev = 2'b00;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 16; i++) begin
      string tag;
      @(posedge clk_rec);
      #1;
      pol_hi   = VEC[i][6];
      rise_sel = VEC[i][5];
      lb_ctl   = VEC[i][4] ? '1 : nonbyp(i);
      {rt_data, rt_flag} = VEC[i][3:2];
      {sl_pos, sl_neg}   = VEC[i][1:0];
      cur = {VEC[i][2], VEC[i][3]};
      if (VEC[i][4]) tag = VEC[i][6] ? "R5 R6 bypass" : "R8 R6 bypass inverted";
      else if (VEC[i][5]) tag = VEC[i][6] ? "R2 R7 R9 rise" : "R4 R2 R9 rise";
      else tag = VEC[i][6] ? "R3 R7 R9 fall" : "R4 R3 R9 fall";
      @(posedge clk_rec);
      #1;
      if (VEC[i][4])      chk(tag, {rx_v, rx_d}, lvl(VEC[i][6], {VEC[i][0], VEC[i][1]}));
      else if (VEC[i][5]) chk(tag, {rx_v, rx_d}, lvl(VEC[i][6], cur));
      else                chk(tag, {rx_v, rx_d}, lvl(VEC[i][6], prev));
      #2;
      if (VEC[i][4]) chk(tag, {rx_v, rx_d}, lvl(VEC[i][6], {VEC[i][0], VEC[i][1]}));
      else           chk(tag, {rx_v, rx_d}, lvl(VEC[i][6], cur));
      prev = cur;
    end

    // R5: combinational bypass, change slicer rails mid-phase
    @(posedge clk_rec);
    #0.5;
    pol_hi = 1'b1; lb_ctl = '1; sl_pos = 1'b1; sl_neg = 1'b0;
    #0.5;
    chk("R5 no clock edge needed", {rx_v, rx_d}, 2'b01);
    sl_pos = 1'b0; sl_neg = 1'b1;
    #0.5;
    chk("R5 follows slicer", {rx_v, rx_d}, 2'b10);

    // R7: one loopback bit cleared keeps retimed path
    lb_ctl = {LB_N{1'b1}} ^ {{(LB_N-1){1'b0}}, 1'b1} << 5;
    rise_sel = 1'b1; rt_data = 1'b1; rt_flag = 1'b1;
    sl_pos = 1'b0; sl_neg = 1'b0;
    @(posedge clk_rec);
    #1;
    chk("R7 one bit cleared", {rx_v, rx_d}, 2'b11);

    // R1: reset again mid-run, active-low
    pol_hi = 1'b0; lb_ctl = '0;
    rst_n = 1'b0;
    #0.5;
    chk("R1 reset mid-run active-low", {rx_v, rx_d}, 2'b11);
    #1 rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule